// File: doc/BRIEF.md
# Complex-Opcode Trap Sequencer

This block sits between instruction decode and execution in a small processor whose 4-bit opcodes fall into three classes. Simple opcodes and I/O opcodes go straight on to the hardware. A complex opcode does not reach the datapath. Instead the sequencer records where main-memory execution must resume, raises a hidden ROM-mode flag, and starts stepping through an emulation routine in a small on-chip ROM. Those routines are written only in simple opcodes.

The block-move routine works on hidden context registers: a source pointer, a destination pointer and a remaining word count. Each pass of its loop issues one copy operation with the current pointers, then advances both pointers and decrements the count. It stops when the count reaches zero. Interrupts are taken only on instruction boundaries. On entry, the mode flag, the ROM position, the resume address and the whole hidden context are saved in a shadow set. They are restored on interrupt return, so an interrupted move continues from where it stopped.

Top module: `cisc_trap_seq`

## Requirements
- R1: In main mode, a completed opcode 0 to 11 is issued unchanged on `iss_op` with `iss_valid` high, and `fetch_pc` advances by one. `iss_io` is high for issued main-mode opcodes 8 to 11. The one exception is opcode 11 while `in_isr` is high, which is never issued.
- R2: A completed opcode 12 to 15 in main mode is not issued. From the next cycle `rom_mode` is 1 and `rom_pc` holds the routine entry: 12→0, 13→4, 14→6, 15→9.
- R3: A trap stores `fetch_pc`+1 as the resume address. ROM opcode 7 is not issued. It clears `rom_mode` and sets `fetch_pc` to that resume address.
- R4: Opcode 12 loads source, destination and count from `mem_a`, `mem_b` and `mem_c`. Its routine is: ROM 0 = test (count 0 → ROM 3, else ROM 1); ROM 1 = copy, issued as opcode 4 with `iss_src`/`iss_dst`; ROM 2 = step (pointers +1, count −1, back to ROM 1 unless the new count is 0); ROM 3 = return. Test and step are never issued.
- R5: Every opcode issued while `rom_mode` is 1 is a simple opcode (below 8).
- R6: A request on `irq` (or one held pending) is taken only on a completed instruction that is not a trap, a ROM return or an interrupt return. The next cycle shows `fetch_pc` = `irq_vec`, `rom_mode` = 0 and `in_isr` = 1.
- R7: Opcode 11 completed in main mode while `in_isr` is 1 restores the mode flag, ROM position, `fetch_pc`, resume address, pointers and count saved at interrupt entry, and clears `in_isr`.
- R8: A request that arrives while `in_isr` is 1, or in a cycle where it cannot be taken, stays pending and is taken at the first eligible boundary. Interrupts never nest.
- R9: While `step_en` is low, no opcode is issued and `fetch_pc`, `rom_pc`, `rom_mode`, `in_isr`, the pointers and the count hold.
- R10: After reset, `fetch_pc` = 0, `rom_pc` = 0, `rom_mode` = 0, `in_isr` = 0 and the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step_en | input | 1 | Current instruction completes this cycle |
| mem_op | input | 4 | Opcode read from main memory at `fetch_pc` |
| mem_a | input | AW | Source operand of the opcode at `fetch_pc` |
| mem_b | input | AW | Destination operand of the opcode at `fetch_pc` |
| mem_c | input | CW | Count operand of the opcode at `fetch_pc` |
| irq | input | 1 | Interrupt request |
| irq_vec | input | AW | Handler start address |
| fetch_pc | output | AW | Main-memory instruction address |
| rom_pc | output | 4 | Routine ROM position |
| rom_mode | output | 1 | Instructions currently come from the ROM |
| in_isr | output | 1 | An interrupt is being serviced |
| iss_valid | output | 1 | An opcode is issued to execution |
| iss_op | output | 4 | Issued opcode |
| iss_io | output | 1 | Issued opcode is an I/O opcode |
| iss_src | output | AW | Current move source pointer |
| iss_dst | output | AW | Current move destination pointer |
| mv_cnt | output | CW | Remaining move count |

## Verification
The program mixes plain simple and I/O opcodes, each of the four complex opcodes, a move with a count of zero and a move of several words. This separates pass-through, entry lookup, the skip path and the loop path. Opcode 7 and opcode 11 also appear in main mode outside a handler, to show that they act as ordinary opcodes there. One interrupt arrives in a stalled cycle in the middle of a move, and the handler itself runs a move, which shows whether the shadow restore brings back the outer pointers and count. A second request during the handler shows that it is held back and taken only after the return. The stall pattern runs throughout and separates hold behaviour from progress.

// File: rtl/cts_pkg.sv
package cts_pkg;
  localparam int OPW = 4;
  localparam int UAW = 4;
  localparam int ROM_DEPTH = 1 << UAW;

  typedef logic [OPW-1:0] op_t;
  typedef logic [UAW-1:0] uaddr_t;

  typedef struct packed {
    op_t    op;
    uaddr_t tgt;
  } uword_t;

  localparam op_t OP_NOP0  = 4'd0;
  localparam op_t OP_COPY  = 4'd4;
  localparam op_t OP_STEP  = 4'd5;
  localparam op_t OP_TEST  = 4'd6;
  localparam op_t OP_RET   = 4'd7;
  localparam op_t OP_IRET  = 4'd11;
  localparam op_t OP_BMOVE = 4'd12;

  function automatic logic op_is_cplx(op_t op);
    return op[3] & op[2];
  endfunction

  function automatic logic op_is_io(op_t op);
    return op[3] & ~op[2];
  endfunction

  function automatic uaddr_t entry_of(op_t op);
    case (op[1:0])
      2'd0:    return uaddr_t'(0);
      2'd1:    return uaddr_t'(4);
      2'd2:    return uaddr_t'(6);
      default: return uaddr_t'(9);
    endcase
  endfunction

  function automatic uword_t rom_word(int addr);
    uword_t w;
    w.op  = OP_RET;
    w.tgt = '0;
    case (addr)
      0: begin w.op = OP_TEST; w.tgt = uaddr_t'(3); end
      1: w.op = OP_COPY;
      2: begin w.op = OP_STEP; w.tgt = uaddr_t'(1); end
      4: w.op = OP_NOP0;
      6: w.op = 4'd1;
      7: w.op = 4'd2;
      default: w.op = OP_RET;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/cts_rom.sv
module cts_rom
  import cts_pkg::*;
(
  input  uaddr_t addr,
  output uword_t data
);
  uword_t tbl [ROM_DEPTH];

  for (genvar gi = 0; gi < ROM_DEPTH; gi++) begin : g_word
    assign tbl[gi] = rom_word(gi);
  end

  assign data = tbl[addr];
endmodule

// File: rtl/cts_decode.sv
module cts_decode
  import cts_pkg::*;
(
  input  op_t  op,
  input  logic rom_mode,
  input  logic in_isr,
  output logic is_trap,
  output logic is_ret,
  output logic is_test,
  output logic is_step,
  output logic is_iret,
  output logic is_issue
);
  always_comb begin
    is_trap  = ~rom_mode & op_is_cplx(op);
    is_iret  = ~rom_mode & in_isr & (op == OP_IRET);
    is_ret   = rom_mode & (op == OP_RET);
    is_test  = rom_mode & (op == OP_TEST);
    is_step  = rom_mode & (op == OP_STEP);
    is_issue = ~(is_trap | is_iret | is_ret | is_test | is_step);
  end
endmodule

// File: rtl/cts_ctx.sv
module cts_ctx
  import cts_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_move,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] dst_in,
  input  logic [CW-1:0] cnt_in,
  input  logic          set_ret,
  input  logic [AW-1:0] ret_in,
  input  logic          do_step,
  input  logic          save,
  input  logic          sv_mode,
  input  uaddr_t        sv_upc,
  input  logic [AW-1:0] sv_pc,
  input  logic          restore,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [CW-1:0] cnt_q,
  output logic [AW-1:0] ret_q,
  output logic          sh_mode,
  output uaddr_t        sh_upc,
  output logic [AW-1:0] sh_pc
);
  localparam logic [AW-1:0] ONE_A = AW'(1);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  logic [AW-1:0] src_n, dst_n, ret_n, sh_src, sh_dst, sh_ret;
  logic [CW-1:0] cnt_n, sh_cnt;
  logic          ctx_en;

  always_comb begin
    src_n = src_q;
    dst_n = dst_q;
    cnt_n = cnt_q;
    ret_n = ret_q;
    if (restore) begin
      src_n = sh_src;
      dst_n = sh_dst;
      cnt_n = sh_cnt;
      ret_n = sh_ret;
    end else begin
      if (ld_move) begin
        src_n = src_in;
        dst_n = dst_in;
        cnt_n = cnt_in;
      end else if (do_step) begin
        src_n = src_q + ONE_A;
        dst_n = dst_q + ONE_A;
        cnt_n = cnt_q - ONE_C;
      end
      if (set_ret) ret_n = ret_in;
    end
    ctx_en = restore | ld_move | do_step | set_ret;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      ret_q <= '0;
    end else if (ctx_en) begin
      src_q <= src_n;
      dst_q <= dst_n;
      cnt_q <= cnt_n;
      ret_q <= ret_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_src  <= '0;
      sh_dst  <= '0;
      sh_cnt  <= '0;
      sh_ret  <= '0;
      sh_mode <= 1'b0;
      sh_upc  <= '0;
      sh_pc   <= '0;
    end else if (save) begin
      sh_src  <= src_n;
      sh_dst  <= dst_n;
      sh_cnt  <= cnt_n;
      sh_ret  <= ret_n;
      sh_mode <= sv_mode;
      sh_upc  <= sv_upc;
      sh_pc   <= sv_pc;
    end
  end

  assert_step_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (do_step && !restore && !ld_move) |=> cnt_q == $past(cnt_q) - ONE_C);

  assert_restore_ctx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> (src_q == $past(sh_src)) && (dst_q == $past(sh_dst)) && (cnt_q == $past(sh_cnt)));
endmodule

// File: rtl/cisc_trap_seq.sv
module cisc_trap_seq
  import cts_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic [3:0]    mem_op,
  input  logic [AW-1:0] mem_a,
  input  logic [AW-1:0] mem_b,
  input  logic [CW-1:0] mem_c,
  input  logic          irq,
  input  logic [AW-1:0] irq_vec,
  output logic [AW-1:0] fetch_pc,
  output logic [3:0]    rom_pc,
  output logic          rom_mode,
  output logic          in_isr,
  output logic          iss_valid,
  output logic [3:0]    iss_op,
  output logic          iss_io,
  output logic [AW-1:0] iss_src,
  output logic [AW-1:0] iss_dst,
  output logic [CW-1:0] mv_cnt
);
  localparam logic [AW-1:0] ONE_A = AW'(1);
  localparam logic [CW-1:0] ONE_C = CW'(1);
  localparam uaddr_t        ONE_U = UAW'(1);

  logic [1:0]    rst_sync;
  logic          rst_q_n;
  logic          mode_q, mode_n, seq_mode;
  uaddr_t        upc_q, upc_n, seq_upc;
  logic [AW-1:0] pc_q, pc_n, seq_pc, pc_inc;
  logic          isr_q, isr_n, pend_q, pend_n, take;
  op_t           cur_op;
  uword_t        uw;
  logic          d_trap, d_ret, d_test, d_step, d_iret, d_issue;
  logic [AW-1:0] src_q, dst_q, ret_q, sh_pc;
  logic [CW-1:0] cnt_q;
  logic          sh_mode;
  uaddr_t        sh_upc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  cts_rom u_rom (.addr(upc_q), .data(uw));

  assign cur_op = mode_q ? uw.op : mem_op;
  assign pc_inc = pc_q + ONE_A;

  cts_decode u_dec (
    .op(cur_op), .rom_mode(mode_q), .in_isr(isr_q),
    .is_trap(d_trap), .is_ret(d_ret), .is_test(d_test),
    .is_step(d_step), .is_iret(d_iret), .is_issue(d_issue)
  );

  cts_ctx #(.AW(AW), .CW(CW)) u_ctx (
    .clk(clk), .rst_n(rst_q_n),
    .ld_move(step_en & d_trap & (cur_op == OP_BMOVE)),
    .src_in(mem_a), .dst_in(mem_b), .cnt_in(mem_c),
    .set_ret(step_en & d_trap), .ret_in(pc_inc),
    .do_step(step_en & d_step),
    .save(take), .sv_mode(seq_mode), .sv_upc(seq_upc), .sv_pc(seq_pc),
    .restore(step_en & d_iret),
    .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q), .ret_q(ret_q),
    .sh_mode(sh_mode), .sh_upc(sh_upc), .sh_pc(sh_pc)
  );

  // sequence step without interrupt, then interrupt override
  always_comb begin
    seq_mode = mode_q;
    seq_upc  = upc_q;
    seq_pc   = pc_q;
    isr_n    = isr_q;
    if (!mode_q) begin
      if (d_trap) begin
        seq_mode = 1'b1;
        seq_upc  = entry_of(cur_op);
      end else if (d_iret) begin
        seq_mode = sh_mode;
        seq_upc  = sh_upc;
        seq_pc   = sh_pc;
        isr_n    = 1'b0;
      end else begin
        seq_pc = pc_inc;
      end
    end else begin
      if (d_ret) begin
        seq_mode = 1'b0;
        seq_pc   = ret_q;
      end else if (d_test) begin
        seq_upc = (cnt_q == '0) ? uw.tgt : upc_q + ONE_U;
      end else if (d_step) begin
        seq_upc = (cnt_q == ONE_C) ? upc_q + ONE_U : uw.tgt;
      end else begin
        seq_upc = upc_q + ONE_U;
      end
    end

    take   = step_en & (pend_q | irq) & ~isr_q & ~d_trap & ~d_ret & ~d_iret;
    mode_n = seq_mode;
    upc_n  = seq_upc;
    pc_n   = seq_pc;
    pend_n = pend_q | irq;
    if (take) begin
      mode_n = 1'b0;
      pc_n   = irq_vec;
      isr_n  = 1'b1;
      pend_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      mode_q <= 1'b0;
      upc_q  <= '0;
      pc_q   <= '0;
      isr_q  <= 1'b0;
    end else if (step_en) begin
      mode_q <= mode_n;
      upc_q  <= upc_n;
      pc_q   <= pc_n;
      isr_q  <= isr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) pend_q <= 1'b0;
    else          pend_q <= pend_n;
  end

  assign fetch_pc  = pc_q;
  assign rom_pc    = upc_q;
  assign rom_mode  = mode_q;
  assign in_isr    = isr_q;
  assign iss_valid = step_en & d_issue;
  assign iss_op    = cur_op;
  assign iss_io    = step_en & d_issue & ~mode_q & op_is_io(cur_op);
  assign iss_src   = src_q;
  assign iss_dst   = dst_q;
  assign mv_cnt    = cnt_q;

  assert_trap_enters_rom_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (step_en && !rom_mode && mem_op[3] && mem_op[2] && !take) |=> rom_mode);

  assert_ret_resumes_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (step_en && rom_mode && uw.op == OP_RET) |=> (!rom_mode && fetch_pc == $past(ret_q)));

  assert_rom_issue_simple_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rom_mode && iss_valid) |-> !iss_op[3]);

  assert_irq_entry_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    take |=> (in_isr && !rom_mode && fetch_pc == $past(irq_vec)));

  assert_no_nest_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_isr && !(step_en && d_iret)) |=> in_isr);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !step_en |=> ($stable(fetch_pc) && $stable(rom_pc) && $stable(rom_mode) && $stable(mv_cnt)));
endmodule

// File: tb/cisc_trap_seq_tb.sv
module cisc_trap_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int CW = 8;
  localparam int VEC = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          step_en = 1'b0;
  logic          irq = 1'b0;
  logic [3:0]    mem_op;
  logic [AW-1:0] mem_a, mem_b;
  logic [CW-1:0] mem_c;
  logic [AW-1:0] fetch_pc, iss_src, iss_dst;
  logic [3:0]    rom_pc, iss_op;
  logic          rom_mode, in_isr, iss_valid, iss_io;
  logic [CW-1:0] mv_cnt;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int prog_op(int a);
    case (a)
      0: return 1;   1: return 9;   2: return 12;  3: return 2;
      4: return 13;  5: return 14;  6: return 15;  7: return 12;
      8: return 7;   9: return 11;  10: return 12;
      40: return 8;  41: return 12; 42: return 11;
      default: return 3;
    endcase
  endfunction
  function automatic int prog_cnt(int a);
    case (a)
      2: return 3; 7: return 0; 10: return 5; 41: return 2;
      default: return 1;
    endcase
  endfunction
  function automatic int rom_op(int u);
    case (u)
      0: return 6; 1: return 4; 2: return 5; 4: return 0; 6: return 1; 7: return 2;
      default: return 7;
    endcase
  endfunction
  function automatic int entry(int op);
    case (op)
      12: return 0; 13: return 4; 14: return 6; default: return 9;
    endcase
  endfunction

  assign mem_op = 4'(prog_op(int'(fetch_pc)));
  assign mem_a  = AW'(int'(fetch_pc) * 16 + 256);
  assign mem_b  = AW'(int'(fetch_pc) * 16 + 4096);
  assign mem_c  = CW'(prog_cnt(int'(fetch_pc)));

  cisc_trap_seq #(.AW(AW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .mem_op(mem_op),
    .mem_a(mem_a), .mem_b(mem_b), .mem_c(mem_c), .irq(irq), .irq_vec(AW'(VEC)),
    .fetch_pc(fetch_pc), .rom_pc(rom_pc), .rom_mode(rom_mode), .in_isr(in_isr),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_io(iss_io),
    .iss_src(iss_src), .iss_dst(iss_dst), .mv_cnt(mv_cnt)
  );

  // reference state
  int m_pc = 0, m_upc = 0, m_ret = 0, m_src = 0, m_dst = 0, m_cnt = 0;
  bit m_mode = 0, m_isr = 0, m_pend = 0;
  int s_pc, s_upc, s_ret, s_src, s_dst, s_cnt;
  bit s_mode;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit fired1 = 0, fired2 = 0;
    int prev_pc, prev_upc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: reset values
    chk(fetch_pc == 0, "R10 fetch_pc", int'(fetch_pc), 0);
    chk(rom_pc == 0, "R10 rom_pc", int'(rom_pc), 0);
    chk(rom_mode == 0, "R10 rom_mode", int'(rom_mode), 0);
    chk(in_isr == 0, "R10 in_isr", int'(in_isr), 0);
    chk(mv_cnt == 0, "R10 mv_cnt", int'(mv_cnt), 0);
    prev_pc = 0;
    prev_upc = 0;
    for (int cyc = 0; cyc < 400; cyc++) begin
      int op, e_valid, e_io, take;
      bit trap, ret, test, stp, iret;
      step_en = (cyc % 7) != 3;
      irq = 1'b0;
      if (!fired1 && m_mode && m_ret == 11 && m_cnt == 3) begin
        fired1 = 1; irq = 1'b1; step_en = 1'b0;
      end else if (!fired2 && m_isr && !m_mode && m_pc == 41) begin
        fired2 = 1; irq = 1'b1;
      end
      #1;
      op   = m_mode ? rom_op(m_upc) : prog_op(m_pc);
      trap = !m_mode && op >= 12;
      iret = !m_mode && m_isr && op == 11;
      ret  = m_mode && op == 7;
      test = m_mode && op == 6;
      stp  = m_mode && op == 5;
      e_valid = step_en && !(trap || iret || ret || test || stp);
      e_io    = e_valid && !m_mode && op >= 8 && op <= 11;
      take    = step_en && (m_pend || irq) && !m_isr && !trap && !ret && !iret;

      chk(fetch_pc == AW'(m_pc), "R3 fetch_pc", int'(fetch_pc), m_pc);
      chk(rom_pc == 4'(m_upc), m_upc < 4 ? "R4 rom_pc" : "R2 rom_pc", int'(rom_pc), m_upc);
      chk(rom_mode == m_mode, "R2 rom_mode", int'(rom_mode), int'(m_mode));
      chk(in_isr == m_isr, "R6 in_isr", int'(in_isr), int'(m_isr));
      chk(iss_valid == 1'(e_valid), "R1 iss_valid", int'(iss_valid), e_valid);
      if (e_valid) chk(iss_op == 4'(op), "R1 iss_op", int'(iss_op), op);
      chk(iss_io == 1'(e_io), "R1 iss_io", int'(iss_io), e_io);
      chk(iss_src == AW'(m_src), "R4 iss_src", int'(iss_src), m_src);
      chk(iss_dst == AW'(m_dst), "R4 iss_dst", int'(iss_dst), m_dst);
      chk(mv_cnt == CW'(m_cnt), "R7 mv_cnt", int'(mv_cnt), m_cnt);
      if (rom_mode && iss_valid) chk(iss_op < 8, "R5 rom issue", int'(iss_op), 7);
      if (fired2 && m_isr && irq) chk(in_isr == 1, "R8 held", int'(in_isr), 1);
      if (cyc > 0 && (cyc % 7) == 4) begin
        chk(int'(rom_pc) == prev_upc || (cyc - 1) % 7 != 3, "R9 upc hold", int'(rom_pc), prev_upc);
      end
      prev_upc = int'(rom_pc);
      prev_pc = int'(fetch_pc);

      @(posedge clk);
      if (step_en) begin
        if (!m_mode) begin
          if (trap) begin
            m_ret = m_pc + 1;
            if (op == 12) begin
              m_src = m_pc * 16 + 256; m_dst = m_pc * 16 + 4096; m_cnt = prog_cnt(m_pc);
            end
            m_mode = 1; m_upc = entry(op);
          end else if (iret) begin
            m_mode = s_mode; m_upc = s_upc; m_pc = s_pc; m_ret = s_ret;
            m_src = s_src; m_dst = s_dst; m_cnt = s_cnt; m_isr = 0;
          end else m_pc = m_pc + 1;
        end else begin
          if (ret) begin m_mode = 0; m_pc = m_ret; end
          else if (test) m_upc = (m_cnt == 0) ? 3 : m_upc + 1;
          else if (stp) begin
            m_src++; m_dst++; m_cnt--;
            m_upc = (m_cnt != 0) ? 1 : m_upc + 1;
          end else m_upc = m_upc + 1;
        end
        if (take) begin
          s_mode = m_mode; s_upc = m_upc; s_pc = m_pc; s_ret = m_ret;
          s_src = m_src; s_dst = m_dst; s_cnt = m_cnt;
          m_mode = 0; m_pc = VEC; m_isr = 1; m_pend = 0;
        end else m_pend = m_pend | irq;
      end else m_pend = m_pend | irq;
      @(negedge clk);
    end
    chk(fired1 && fired2, "R8 scenario reached", int'(fired1) + int'(fired2), 2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule